// File: doc/BRIEF.md
# Blocking Overreach Trip Logic

This block decides, for one end of a protected transmission line, what to signal to the remote end and when the local breaker may be ordered to open. It uses a blocking overreach scheme. By default the terminal sends permission. It sends a blocking command only when its reverse-looking element sees a fault behind it and the chosen forward overreaching zone (zone 2 or zone 3, picked by a setting) is quiet. The local trip command is given only when the chosen forward zone has operated and the remote end is sending permission. Both conditions must hold for a programmable pickup time, which allows for the channel delay of a late blocking command.

Two guards shape the transmitted signal. A current-reversal guard applies when the blocking condition has held without a break for a fixed detection time (20 ms by default). From then on, the blocking command is kept on for a programmable hold time after the condition clears. This covers the moment when fault current on a parallel line changes direction. A post-trip guard forces permission while the local breaker is reported tripped, and for a programmable time after that, so that the remote end can still trip. This guard has priority over every blocking request. All timing counts a 1 ms tick input.

Top module: `bop_scheme`

## Requirements
- R1: While `rst_n` is low at a clock edge, all timers are cleared and `tx_blocking`, `trip_single` and `trip_three` read 0 after that edge.
- R2: With the reverse element inactive, no reversal hold pending and no trip activity, `tx_blocking` is 0 (permission; 1 means block on both the transmit and receive lines).
- R3: `tx_blocking` is 1 in the same cycle that `rev_fault` is 1 and the selected forward zone is 0. The zone is selected by `fwd_sel_z3`: 0 selects `fwd_zone2` and 1 selects `fwd_zone3`.
- R4: If the blocking condition holds for `REV_DETECT_MS` ticks without a break, `tx_blocking` stays 1 after the condition clears, until `cfg_rev_hold_ms` ticks have passed. A shorter blocking condition gives no hold.
- R5: While `breaker_tripped` is 1, and until `cfg_post_trip_ms` ticks after it falls, `tx_blocking` is 0 whatever the blocking request.
- R6: A trip is set one clock after the selected forward zone is 1 and `rx_blocked` is 0 have both held through `cfg_pickup_ms` ticks. Any break in either condition restarts that count from zero.
- R7: When a trip is set, `trip_mode_3ph` = 1 drives `trip_three` and 0 drives `trip_single`. The two are never 1 together.
- R8: A preset of zero makes its delay or extension transparent. With a zero pickup, a trip sets on the clock after qualification. With a zero post-trip time, blocking resumes in the cycle after `breaker_tripped` falls.
- R9: Once qualification is lost, the trip outputs clear at the first tick edge and hold their value on the clock edges before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| rev_fault | input | 1 | Reverse-looking element operated |
| fwd_zone2 | input | 1 | Forward zone 2 element operated |
| fwd_zone3 | input | 1 | Forward zone 3 element operated |
| fwd_sel_z3 | input | 1 | Overreach zone select: 0 zone 2, 1 zone 3 |
| rx_blocked | input | 1 | Received channel: 1 block, 0 permission |
| breaker_tripped | input | 1 | Local terminal trip status |
| trip_mode_3ph | input | 1 | 1 three-phase trip, 0 single-phase trip |
| cfg_pickup_ms | input | CNT_W | Trip pickup delay preset in ticks |
| cfg_rev_hold_ms | input | CNT_W | Reversal block hold preset in ticks |
| cfg_post_trip_ms | input | CNT_W | Post-trip permission preset in ticks |
| tx_blocking | output | 1 | Transmitted channel: 1 block, 0 permission |
| trip_single | output | 1 | Single-phase trip command |
| trip_three | output | 1 | Three-phase trip command |

## Verification
The reversal hold and the post-trip permission override can both apply to the transmit line in the same cycle, with opposite intent. Random stimulus keeps the reverse element asserted for long runs while the breaker status toggles, so many cycles have an armed hold and an active override together. Every cycle is compared against a bench model in which the override always wins. A second coincidence is a lost trip qualification on a cycle with a tick versus one without. Directed steps check that the trip output clears only on the tick edge.

// File: rtl/bop_pkg.sv
// Package: shared types and helpers for the blocking overreach trip logic.
// Assumes: forward zone selection is a single setting bit.
package bop_pkg;

    // Which forward element acts as the overreaching zone.
    typedef enum logic {
        FWD_ZONE2 = 1'b0,
        FWD_ZONE3 = 1'b1
    } fwd_zone_e;

    // Pick the active forward overreaching element.
    function automatic logic pick_forward(input fwd_zone_e sel, input logic z2, input logic z3);
        return (sel == FWD_ZONE3) ? z3 : z2;
    endfunction

endpackage

// File: rtl/bop_ontimer.sv
// Module: pickup (on-delay) timer.
// done is 1 while cond is 1 and cond has held through `preset` ticks.
// Any cycle with cond low clears the count. A zero preset passes cond straight through.
// Assumes tick is a single-cycle pulse.
module bop_ontimer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cond,
    input  logic [CNT_W-1:0] preset,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count ticks while the condition holds; restart when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick && (cnt < preset)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expired once the count has reached the preset.
    always_comb begin
        done = cond && (cnt >= preset);
    end

    // R6: a cycle without the condition leaves the count at zero.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));

endmodule

// File: rtl/bop_offdelay.sv
// Module: drop-off extension timer.
// out follows lvl, and after lvl falls it stays 1 for `preset` ticks.
// A zero preset adds no extension. Assumes tick is a single-cycle pulse.
module bop_offdelay #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lvl,
    input  logic [CNT_W-1:0] preset,
    output logic             out
);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    // Arm while the level is high; after it falls, count ticks to expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (lvl) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && tick) begin
            if (({1'b0, cnt} + 1'b1) >= {1'b0, preset}) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Level or still-running extension.
    always_comb begin
        out = lvl || (armed && (cnt < preset));
    end

    // R4 / R5: with a non-zero preset the output holds on the cycle the level falls.
    a_r4_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((preset != '0) && $fell(lvl)) |-> out);

endmodule

// File: rtl/bop_send_ctrl.sv
// Module: transmit channel control.
// The blocking request is reverse fault with the forward zone quiet.
// A long request arms the reversal hold. The post-trip override forces permission.
// Assumes fwd_active is already the selected overreaching zone.
module bop_send_ctrl #(
    parameter int CNT_W         = 16,
    parameter int REV_DETECT_MS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rev_fault,
    input  logic             fwd_active,
    input  logic             breaker_tripped,
    input  logic [CNT_W-1:0] rev_hold,
    input  logic [CNT_W-1:0] post_trip,
    output logic             tx_blocking
);

    localparam logic [CNT_W-1:0] REV_PRESET = CNT_W'(REV_DETECT_MS);

    logic block_req;
    logic rev_picked;
    logic rev_extended;
    logic permit_force;

    // Raw blocking request.
    always_comb begin
        block_req = rev_fault && !fwd_active;
    end

    // Reversal detection: the request must persist for the fixed window.
    bop_ontimer #(.CNT_W(CNT_W)) u_rev_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cond   (block_req),
        .preset (REV_PRESET),
        .done   (rev_picked)
    );

    // Reversal hold: stretch the block after detection clears.
    bop_offdelay #(.CNT_W(CNT_W)) u_rev_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .lvl    (rev_picked),
        .preset (rev_hold),
        .out    (rev_extended)
    );

    // Post-trip permission extension.
    bop_offdelay #(.CNT_W(CNT_W)) u_post_trip (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .lvl    (breaker_tripped),
        .preset (post_trip),
        .out    (permit_force)
    );

    // Transmit: the override wins over any block source.
    always_comb begin
        tx_blocking = !permit_force && (block_req || rev_extended);
    end

    // R3: a live request with no override must be sent as block.
    a_r3_block_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (block_req && !permit_force) |-> tx_blocking);

endmodule

// File: rtl/bop_trip_ctrl.sv
// Module: trip decision.
// Qualification is the forward zone active with permission received, held through the pickup time.
// The registered trip outputs then follow the mode. They clear on the first tick after qualification is lost.
module bop_trip_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fwd_active,
    input  logic             rx_blocked,
    input  logic             mode_3ph,
    input  logic [CNT_W-1:0] pickup,
    output logic             trip_single,
    output logic             trip_three
);

    logic qual;
    logic qual_done;

    // Forward fault seen and no block received.
    always_comb begin
        qual = fwd_active && !rx_blocked;
    end

    // Channel-delay pickup timer.
    bop_ontimer #(.CNT_W(CNT_W)) u_pickup (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cond   (qual),
        .preset (pickup),
        .done   (qual_done)
    );

    // Register the trip command; drop it only on a tick edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_single <= 1'b0;
            trip_three  <= 1'b0;
        end else if (qual_done) begin
            trip_single <= !mode_3ph;
            trip_three  <= mode_3ph;
        end else if (tick && !qual) begin
            trip_single <= 1'b0;
            trip_three  <= 1'b0;
        end
    end

    // R9: lost qualification on a tick clears both trip outputs.
    a_r9_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !qual) |=> !(trip_single || trip_three));

endmodule

// File: rtl/bop_scheme.sv
// Module: top of the blocking overreach trip logic.
// Selects the overreaching zone, then feeds the transmit and trip controllers.
// Assumes tick_1ms is a single-cycle pulse and presets are static or change slowly.
module bop_scheme #(
    parameter int CNT_W         = 16,
    parameter int REV_DETECT_MS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             rev_fault,
    input  logic             fwd_zone2,
    input  logic             fwd_zone3,
    input  logic             fwd_sel_z3,
    input  logic             rx_blocked,
    input  logic             breaker_tripped,
    input  logic             trip_mode_3ph,
    input  logic [CNT_W-1:0] cfg_pickup_ms,
    input  logic [CNT_W-1:0] cfg_rev_hold_ms,
    input  logic [CNT_W-1:0] cfg_post_trip_ms,
    output logic             tx_blocking,
    output logic             trip_single,
    output logic             trip_three
);

    import bop_pkg::*;

    fwd_zone_e zone_sel;
    logic      fwd_active;

    // Decode the overreach selection setting.
    always_comb begin
        zone_sel   = fwd_sel_z3 ? FWD_ZONE3 : FWD_ZONE2;
        fwd_active = pick_forward(zone_sel, fwd_zone2, fwd_zone3);
    end

    bop_send_ctrl #(.CNT_W(CNT_W), .REV_DETECT_MS(REV_DETECT_MS)) u_send (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick_1ms),
        .rev_fault       (rev_fault),
        .fwd_active      (fwd_active),
        .breaker_tripped (breaker_tripped),
        .rev_hold        (cfg_rev_hold_ms),
        .post_trip       (cfg_post_trip_ms),
        .tx_blocking     (tx_blocking)
    );

    bop_trip_ctrl #(.CNT_W(CNT_W)) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_1ms),
        .fwd_active  (fwd_active),
        .rx_blocked  (rx_blocked),
        .mode_3ph    (trip_mode_3ph),
        .pickup      (cfg_pickup_ms),
        .trip_single (trip_single),
        .trip_three  (trip_three)
    );

    // R5: the breaker status forces permission on the line.
    a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        breaker_tripped |-> !tx_blocking);

    // R7: never both trip flavours at once.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trip_single && trip_three));

    // R6: a trip can only rise after a qualified cycle.
    a_r6_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_single || trip_three) |-> $past(fwd_active && !rx_blocked));

endmodule

// File: tb/tb_bop_scheme.sv
// Bench: directed corner cases plus seeded random stimulus checked against a bench model.
module tb_bop_scheme;

    localparam int W   = 16;
    localparam int REV = 20;

    logic clk = 1'b0;
    logic rst_n, tick, rev, z2, z3, zsel, rxb, ltrip, m3;
    logic [W-1:0] p_pick, p_hold, p_ext;
    logic tx, t1, t3;

    int nchk  = 0;
    int nfail = 0;
    bit done_run = 0;

    always #10 clk = ~clk;

    bop_scheme #(.CNT_W(W), .REV_DETECT_MS(REV)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .rev_fault(rev),
        .fwd_zone2(z2), .fwd_zone3(z3), .fwd_sel_z3(zsel), .rx_blocked(rxb),
        .breaker_tripped(ltrip), .trip_mode_3ph(m3),
        .cfg_pickup_ms(p_pick), .cfg_rev_hold_ms(p_hold), .cfg_post_trip_ms(p_ext),
        .tx_blocking(tx), .trip_single(t1), .trip_three(t3)
    );

    // Bench model state, written from the requirements.
    int m_pc, m_rc, m_rh, m_ec;
    bit m_ra, m_ea, m_t1, m_t3;

    function automatic bit e_fsel();  return zsel ? z3 : z2;          endfunction
    function automatic bit e_qual();  return e_fsel() && !rxb;        endfunction
    function automatic bit e_breq();  return rev && !e_fsel();        endfunction
    function automatic bit e_done();  return e_qual() && (m_pc >= int'(p_pick)); endfunction
    function automatic bit e_rpick(); return e_breq() && (m_rc >= REV); endfunction
    function automatic bit e_tx();
        bit rext, eext;
        rext = e_rpick() || (m_ra && (m_rh < int'(p_hold)));
        eext = ltrip || (m_ea && (m_ec < int'(p_ext)));
        return !eext && (e_breq() || rext);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc <= 0; m_rc <= 0; m_rh <= 0; m_ec <= 0;
            m_ra <= 0; m_ea <= 0; m_t1 <= 0; m_t3 <= 0;
        end else begin
            m_pc <= !e_qual() ? 0 : ((tick && m_pc < int'(p_pick)) ? m_pc + 1 : m_pc);
            m_rc <= !e_breq() ? 0 : ((tick && m_rc < REV) ? m_rc + 1 : m_rc);
            if (e_rpick()) begin m_ra <= 1; m_rh <= 0; end
            else if (m_ra && tick) begin
                if (m_rh + 1 >= int'(p_hold)) begin m_ra <= 0; m_rh <= 0; end
                else m_rh <= m_rh + 1;
            end
            if (ltrip) begin m_ea <= 1; m_ec <= 0; end
            else if (m_ea && tick) begin
                if (m_ec + 1 >= int'(p_ext)) begin m_ea <= 0; m_ec <= 0; end
                else m_ec <= m_ec + 1;
            end
            if (e_done()) begin m_t1 <= !m3; m_t3 <= m3; end
            else if (tick && !e_qual()) begin m_t1 <= 0; m_t3 <= 0; end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock; inputs change 2 ns after the edge.
    task automatic adv(input bit t);
        tick = t;
        @(posedge clk);
        #2;
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; tick = 0; rev = 0; z2 = 0; z3 = 0; zsel = 0; rxb = 0;
        ltrip = 0; m3 = 0; p_pick = '0; p_hold = '0; p_ext = '0;
        repeat (3) adv(0);
        chk("R1 tx", tx, 0); chk("R1 t1", t1, 0); chk("R1 t3", t3, 0);
        rst_n = 1;
        adv(0);
        #1 chk("R2 quiet", tx, 0);

        // R3 zone selection.
        rev = 1; z3 = 1; zsel = 0; rxb = 1;
        #1 chk("R3 zone2 quiet -> block", tx, 1);
        zsel = 1;
        #1 chk("R3 zone3 active -> permit", tx, 0);
        rev = 0; z3 = 0; zsel = 0; rxb = 0;
        adv(1); adv(1);

        // R6 pickup with 3 ticks.
        p_pick = 3; z2 = 1; m3 = 0;
        adv(1); adv(1);
        #1 chk("R6 before pickup", t1, 0);
        adv(1);
        #1 chk("R6 registered one clock later", t1, 0);
        adv(0);
        #1 chk("R6 trip set", t1, 1);
        // R9 hold until a tick.
        rxb = 1;
        adv(0); adv(0);
        #1 chk("R9 held without tick", t1, 1);
        adv(1);
        #1 chk("R9 cleared on tick", t1, 0);
        // R6 restart.
        rxb = 0; adv(1); adv(1);
        rxb = 1; adv(0);
        rxb = 0; adv(1); adv(1); adv(0);
        #1 chk("R6 restart after break", t1, 0);
        adv(1); adv(0);
        #1 chk("R6 trip after full count", t1, 1);
        // R7 mode.
        m3 = 1; adv(0);
        #1 chk("R7 three-phase", t3, 1);
        chk("R7 single off", t1, 0);
        z2 = 0; adv(1); adv(0);

        // R8 zero pickup and zero post-trip.
        p_pick = 0; z2 = 1; adv(0);
        #1 chk("R8 zero pickup trip", t3, 1);
        z2 = 0; adv(1);
        rev = 1; ltrip = 1;
        #1 chk("R5 override while tripped", tx, 0);
        adv(0);
        ltrip = 0;
        #1 chk("R8 zero post-trip", tx, 1);
        rev = 0; adv(0);

        // R4 reversal hold of 3 ticks.
        p_hold = 3; rev = 1;
        for (int i = 0; i < REV; i++) adv(1);
        adv(0);
        rev = 0;
        #1 chk("R4 hold starts", tx, 1);
        adv(1); adv(1);
        #1 chk("R4 hold two ticks", tx, 1);
        adv(1);
        #1 chk("R4 hold expired", tx, 0);
        rev = 1;
        for (int i = 0; i < 5; i++) adv(1);
        rev = 0;
        #1 chk("R4 short request no hold", tx, 0);

        // R5 post-trip extension of 2 ticks.
        p_hold = 0; p_ext = 2; rev = 1; ltrip = 1;
        adv(1);
        #1 chk("R5 tripped", tx, 0);
        ltrip = 0; adv(1);
        #1 chk("R5 extension running", tx, 0);
        adv(1);
        #1 chk("R5 extension over", tx, 1);
        rev = 0; adv(0);

        // Random phase against the bench model.
        for (int c = 0; c < 30000; c++) begin
            if (c % 3000 == 0) begin
                p_pick = W'($urandom % 5);
                p_hold = W'($urandom % 6);
                p_ext  = W'($urandom % 4);
            end
            if ($urandom % 64 == 0) rev   = ~rev;
            if ($urandom % 64 == 0) z2    = ~z2;
            if ($urandom % 64 == 0) z3    = ~z3;
            if ($urandom % 200 == 0) zsel = ~zsel;
            if ($urandom % 24 == 0) rxb   = ~rxb;
            if ($urandom % 90 == 0) ltrip = ~ltrip;
            if ($urandom % 150 == 0) m3   = ~m3;
            #1;
            chk("R3 R4 R5 tx model", tx, e_tx());
            chk("R6 R7 R9 single model", t1, m_t1);
            chk("R6 R7 R9 three model", t3, m_t3);
            adv(($urandom % 4) == 0);
        end

        done_run = 1;
        summary();
        $finish;
    end

endmodule